// File: doc/BRIEF.md
# Lockable Control Register Bank

This block holds the configuration of a stepper-motor driver. It sits behind a serial front end that has already decoded each transaction. That front end hands the bank one write strobe and one read strobe per clock, each with an 8-bit address and, for writes, an 8-bit data byte.

The bank has eleven byte locations:

| Address | Access | Contents |
|---|---|---|
| 0x00, 0x01, 0x02 | read-only | Three status bytes, supplied live from input ports |
| 0x03 to 0x08 | read/write | Six control bytes, each with its own reset default |
| 0x09 | read-only | A torque-count byte, sampled from an input port every clock |
| 0x0A | read-only | A revision byte |

The six control bytes are also presented on a flat output bus so that the driver logic can use them directly.

Three command bits clear themselves:
- The step command clears one cycle after a 1 is written.
- The clear-fault command clears one cycle after a 1 is written.
- The stall-learn command stays set until the learning engine returns a done pulse.

A 3-bit lock field at address 0x06 protects the control bytes. Only code 110b engages the lock, and only code 011b releases it. While the lock is engaged, the only write that takes effect is a write to address 0x06, and it can touch only the lock field and the clear-fault bit.

Top module: `cfg_regbank`

## Requirements
- R1: A read returns, by address: 0x00/0x01/0x02 the stat0_in/stat1_in/stat2_in ports; 0x03 to 0x08 the control bytes; 0x09 the count register; 0x0A {4'b0000, REV}, where REV defaults to 4'b0010. Every other address reads 0x00.
- R2: After reset the control bytes are 0x03=0x00, 0x04=0x0F, 0x05=0x00, 0x06=0x30, 0x07=0x08 and 0x08=0x0F, and the count register is 0xFF. cfg_bytes places address 0x03 in bits 7:0, up to address 0x08 in bits 47:40.
- R3: rd_data is registered. It changes only on the clock edge at which rd_en is high and then shows the value held before that edge. A read and a write to the same address in one cycle therefore return the old value.
- R4: While unlocked, a write to addresses 0x03 to 0x08 stores the whole data byte. The only exception is the lock field, bits 6:4 of 0x06, which follows R5.
- R5: While unlocked, writing lock code 110b sets the field to 110b and raises `locked`. Any other code leaves the field at 011b.
- R6: While locked, writes to 0x03 to 0x08 change nothing, with two exceptions at 0x06. Bit 7 (clear-fault) is still written. Lock code 011b releases the lock, and any other code has no effect.
- R7: The step bit (0x05 bit 6) and the clear-fault bit (0x06 bit 7) read 1 for exactly one cycle after a 1 is written, then return to 0.
- R8: The stall-learn bit (0x07 bit 5) stays at 1 after being written until learn_done is high at a clock edge, which clears it. A write of 1 in that same cycle wins.
- R9: Writes to read-only addresses (0x00 to 0x02, 0x09, 0x0A) and to reserved addresses change no register.
- R10: The count register captures count_in on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| stat0_in | input | 8 | Status byte for address 0x00 |
| stat1_in | input | 8 | Status byte for address 0x01 |
| stat2_in | input | 8 | Status byte for address 0x02 |
| count_in | input | 8 | Torque count sampled into 0x09 |
| learn_done | input | 1 | Stall learning finished; clears the learn bit |
| cfg_bytes | output | 48 | Control bytes 0x03 to 0x08, lowest address in the low byte |
| locked | output | 1 | Lock engaged |

## Verification
The bench attacks the lock from both sides:
- A near-miss code such as 101b while unlocked must leave the bank writable. A bank that engaged on any nonzero code would freeze later writes.
- A locked write of 0x8F must pulse the clear-fault bit while keeping the lower bits of 0x06. A bank that dropped all locked writes would lose the pulse, and one that stored the whole byte would corrupt the other fields.

The self-clearing bits are checked at the exact cycle they should fall, so a step bit that stayed high would repeat steps. The learn bit is watched across several idle cycles, where a one-cycle clear would abort learning early.

A same-cycle write and read of one address must return the old value, and reserved addresses must read zero.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int NUM_CTL   = 6;
    localparam int CTL_FIRST = 3;
    localparam int CTL_LAST  = CTL_FIRST + NUM_CTL - 1;
    localparam int CNT_ADDR  = 9;
    localparam int REV_ADDR  = 10;

    // control byte indices (address minus CTL_FIRST)
    localparam int IDX_MOTION = 2;   // 0x05
    localparam int IDX_PROT   = 3;   // 0x06
    localparam int IDX_STALL  = 4;   // 0x07

    localparam int BIT_STEP  = 6;
    localparam int BIT_CLEAR = 7;
    localparam int BIT_LEARN = 5;

    localparam logic [2:0] LOCK_SET   = 3'b110;
    localparam logic [2:0] LOCK_CLEAR = 3'b011;

    typedef logic [NUM_CTL-1:0][DATA_W-1:0] ctl_bank_t;

    typedef struct packed {
        ctl_bank_t         ctl;
        logic [DATA_W-1:0] cnt;
    } bank_state_t;

    function automatic logic [DATA_W-1:0] ctl_default(input int idx);
        case (idx)
            1:       return 8'h0F;
            3:       return {1'b0, LOCK_CLEAR, 4'h0};
            4:       return 8'h08;
            5:       return 8'h0F;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfg_ctl_file.sv
module cfg_ctl_file
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] count_in,
    input  logic              learn_done,
    output ctl_bank_t         ctl,
    output logic [DATA_W-1:0] cnt,
    output logic              locked
);
    bank_state_t st_d, st_q;
    logic        lock_q;

    assign lock_q = (st_q.ctl[IDX_PROT][6:4] == LOCK_SET);

    always_comb begin
        st_d = st_q;
        st_d.cnt = count_in;
        st_d.ctl[IDX_MOTION][BIT_STEP] = 1'b0;
        st_d.ctl[IDX_PROT][BIT_CLEAR]  = 1'b0;
        if (learn_done) st_d.ctl[IDX_STALL][BIT_LEARN] = 1'b0;
        for (int i = 0; i < NUM_CTL; i++) begin
            if (wr_en && wr_addr == ADDR_W'(CTL_FIRST + i)) begin
                if (i == IDX_PROT) begin
                    st_d.ctl[i][BIT_CLEAR] = wr_data[BIT_CLEAR];
                    if (!lock_q) begin
                        st_d.ctl[i][3:0] = wr_data[3:0];
                        st_d.ctl[i][6:4] = (wr_data[6:4] == LOCK_SET) ? LOCK_SET : LOCK_CLEAR;
                    end else if (wr_data[6:4] == LOCK_CLEAR) begin
                        st_d.ctl[i][6:4] = LOCK_CLEAR;
                    end
                end else if (!lock_q) begin
                    st_d.ctl[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTL; i++) st_q.ctl[i] <= ctl_default(i);
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl    = st_q.ctl;
    assign cnt    = st_q.cnt;
    assign locked = lock_q;

    // lock field only ever holds one of its two codes
    assert_lock_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[IDX_PROT][6:4] == LOCK_SET) || (st_q.ctl[IDX_PROT][6:4] == LOCK_CLEAR));

    assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(st_q.ctl[0]) && $stable(st_q.ctl[1]) && $stable(st_q.ctl[5]));

    assert_stays_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !(wr_en && wr_addr == ADDR_W'(CTL_FIRST + IDX_PROT))) |=> lock_q);

    assert_step_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[IDX_MOTION][BIT_STEP] && !wr_en) |=> !st_q.ctl[IDX_MOTION][BIT_STEP]);

    assert_clear_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[IDX_PROT][BIT_CLEAR] && !wr_en) |=> !st_q.ctl[IDX_PROT][BIT_CLEAR]);

    assert_learn_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl[IDX_STALL][BIT_LEARN] && !learn_done) |=> st_q.ctl[IDX_STALL][BIT_LEARN]);

    assert_count_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt == $past(count_in));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_regbank_pkg::*;
#(
    parameter logic [3:0] REV = 4'b0010
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] stat0,
    input  logic [DATA_W-1:0] stat1,
    input  logic [DATA_W-1:0] stat2,
    input  ctl_bank_t         ctl,
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        case (addr)
            8'h00: data = stat0;
            8'h01: data = stat1;
            8'h02: data = stat2;
            ADDR_W'(CNT_ADDR): data = cnt;
            ADDR_W'(REV_ADDR): data = {4'b0000, REV};
            default: begin
                for (int i = 0; i < NUM_CTL; i++)
                    if (addr == ADDR_W'(CTL_FIRST + i)) data = ctl[i];
            end
        endcase
    end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter logic [3:0] REV = 4'b0010
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    input  logic                      rd_en,
    input  logic [7:0]                rd_addr,
    output logic [7:0]                rd_data,
    input  logic [7:0]                stat0_in,
    input  logic [7:0]                stat1_in,
    input  logic [7:0]                stat2_in,
    input  logic [7:0]                count_in,
    input  logic                      learn_done,
    output logic [47:0]               cfg_bytes,
    output logic                      locked
);
    ctl_bank_t         ctl;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] mux_data;
    logic [DATA_W-1:0] rd_d, rd_q;

    cfg_ctl_file u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_in(count_in), .learn_done(learn_done),
        .ctl(ctl), .cnt(cnt), .locked(locked)
    );

    cfg_read_mux #(.REV(REV)) u_mux (
        .addr(rd_addr), .stat0(stat0_in), .stat1(stat1_in), .stat2(stat2_in),
        .ctl(ctl), .cnt(cnt), .data(mux_data)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en) rd_d = mux_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data   = rd_q;
    assign cfg_bytes = ctl;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > 8'h0A) |=> rd_data == 8'h00);

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_rev_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 8'h0A) |=> rd_data == {4'b0000, REV});
endmodule

// File: tb/cfg_regbank_tb.sv
module cfg_regbank_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0, learn_done = 0;
    logic [7:0]  wr_addr = 0, wr_data = 0, rd_addr = 0;
    logic [7:0]  stat0_in = 8'hA5, stat1_in = 8'h3C, stat2_in = 8'h81, count_in = 8'h00;
    logic [7:0]  rd_data;
    logic [47:0] cfg_bytes;
    logic        locked;

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference
    logic [7:0] m_ctl [0:5];
    logic [7:0] m_cnt, m_rd;
    bit         m_lock;

    always #10 clk = ~clk;

    cfg_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .stat0_in(stat0_in), .stat1_in(stat1_in), .stat2_in(stat2_in),
        .count_in(count_in), .learn_done(learn_done),
        .cfg_bytes(cfg_bytes), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return stat0_in;
        if (a == 8'h01) return stat1_in;
        if (a == 8'h02) return stat2_in;
        if (a >= 8'h03 && a <= 8'h08) return m_ctl[a - 8'h03];
        if (a == 8'h09) return m_cnt;
        if (a == 8'h0A) return 8'h02;
        return 8'h00;
    endfunction

    task automatic model_reset();
        m_ctl[0] = 8'h00; m_ctl[1] = 8'h0F; m_ctl[2] = 8'h00;
        m_ctl[3] = 8'h30; m_ctl[4] = 8'h08; m_ctl[5] = 8'h0F;
        m_cnt = 8'hFF; m_rd = 8'h00; m_lock = 0;
    endtask

    task automatic model_step();
        if (rd_en) m_rd = model_read(rd_addr);
        m_ctl[2][6] = 0;
        m_ctl[3][7] = 0;
        if (learn_done) m_ctl[4][5] = 0;
        if (wr_en && wr_addr >= 8'h03 && wr_addr <= 8'h08) begin
            int k = int'(wr_addr) - 3;
            if (k == 3) begin
                m_ctl[3][7] = wr_data[7];
                if (!m_lock) begin
                    m_ctl[3][3:0] = wr_data[3:0];
                    m_lock = (wr_data[6:4] == 3'b110);
                    m_ctl[3][6:4] = m_lock ? 3'b110 : 3'b011;
                end else if (wr_data[6:4] == 3'b011) begin
                    m_lock = 0;
                    m_ctl[3][6:4] = 3'b011;
                end
            end else if (!m_lock) begin
                m_ctl[k] = wr_data;
            end
        end
        m_cnt = count_in;
    endtask

    function automatic logic [47:0] model_bus();
        return {m_ctl[5], m_ctl[4], m_ctl[3], m_ctl[2], m_ctl[1], m_ctl[0]};
    endfunction

    // one clock with given strobes; compares against the model at the following negedge
    task automatic tick(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit re, input logic [7:0] ra, input bit ld);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; learn_done = ld;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 0; rd_en = 0; learn_done = 0;
        check(cfg_bytes == model_bus(), "R4 model cfg_bytes", cfg_bytes, model_bus());
        check(locked == m_lock, "R6 model locked", 48'(locked), 48'(m_lock));
        check(rd_data == m_rd, "R3 model rd_data", 48'(rd_data), 48'(m_rd));
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        tick(1, a, d, 0, 0, 0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        tick(0, 0, 0, 1, a, 0);
        v = rd_data;
    endtask

    task automatic idle();
        tick(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<20000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_def [0:10];
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 reset defaults, R1 map (status, count, revision)
        exp_def = '{8'hA5, 8'h3C, 8'h81, 8'h00, 8'h0F, 8'h00, 8'h30, 8'h08, 8'h0F, 8'hFF, 8'h02};
        check(cfg_bytes == 48'h0F_08_30_00_0F_00, "R2 reset cfg_bytes", cfg_bytes, 48'h0F_08_30_00_0F_00);
        check(locked == 0, "R2 reset unlocked", 48'(locked), 0);
        count_in = 8'hFF;
        for (int a = 0; a < 11; a++) begin
            rd(8'(a), v);
            check(v == exp_def[a], (a < 3 || a > 8) ? "R1 read map" : "R2 default read", 48'(v), 48'(exp_def[a]));
        end

        // R4 plain write, R9 reserved/read-only writes ignored
        wr(8'h03, 8'h5A);
        rd(8'h03, v); check(v == 8'h5A, "R4 write 0x03", 48'(v), 48'h5A);
        wr(8'h40, 8'hEE);
        rd(8'h40, v); check(v == 8'h00, "R9 reserved reads 0", 48'(v), 0);
        wr(8'h00, 8'h11);
        wr(8'h0A, 8'h77);
        wr(8'h09, 8'h12);
        rd(8'h00, v); check(v == 8'hA5, "R9 status unaffected", 48'(v), 48'hA5);
        rd(8'h0A, v); check(v == 8'h02, "R9 revision unaffected", 48'(v), 48'h02);
        check(cfg_bytes == 48'h0F_08_30_00_0F_5A, "R9 control bytes unaffected", cfg_bytes, 48'h0F_08_30_00_0F_5A);

        // R3 same-cycle write and read returns old value
        tick(1, 8'h08, 8'hC3, 1, 8'h08, 0);
        check(rd_data == 8'h0F, "R3 same-cycle old value", 48'(rd_data), 48'h0F);
        rd(8'h08, v); check(v == 8'hC3, "R3 new value next read", 48'(v), 48'hC3);

        // R7 step and clear-fault self-clear
        wr(8'h05, 8'h4F);
        check(cfg_bytes[22] == 1, "R7 step high one cycle", 48'(cfg_bytes[22]), 1);
        idle();
        check(cfg_bytes[23:16] == 8'h0F, "R7 step cleared", 48'(cfg_bytes[23:16]), 48'h0F);
        wr(8'h06, 8'hB8);
        check(cfg_bytes[31:24] == 8'hB8, "R7 clear-fault high", 48'(cfg_bytes[31:24]), 48'hB8);
        idle();
        check(cfg_bytes[31:24] == 8'h38, "R7 clear-fault cleared", 48'(cfg_bytes[31:24]), 48'h38);

        // R5 lock codes while unlocked
        wr(8'h06, 8'h50);
        check(locked == 0 && cfg_bytes[31:24] == 8'h30, "R5 code 101 ignored", cfg_bytes[31:24], 48'h30);
        wr(8'h06, 8'h70);
        check(locked == 0 && cfg_bytes[31:24] == 8'h30, "R5 code 111 ignored", cfg_bytes[31:24], 48'h30);
        wr(8'h06, 8'h60);
        check(locked == 1 && cfg_bytes[31:24] == 8'h60, "R5 code 110 locks", cfg_bytes[31:24], 48'h60);

        // R6 locked behaviour
        wr(8'h03, 8'hFF);
        wr(8'h05, 8'h40);
        check(cfg_bytes[7:0] == 8'h5A && cfg_bytes[22] == 0, "R6 writes ignored", cfg_bytes[23:0], 48'h0F0F5A);
        wr(8'h06, 8'h8F);
        check(cfg_bytes[31:24] == 8'hE0 && locked, "R6 clear-fault passes lock", cfg_bytes[31:24], 48'hE0);
        idle();
        wr(8'h06, 8'h00);
        check(locked == 1, "R6 code 000 keeps lock", 48'(locked), 1);
        wr(8'h06, 8'h30);
        check(locked == 0 && cfg_bytes[31:24] == 8'h30, "R6 code 011 unlocks", cfg_bytes[31:24], 48'h30);
        wr(8'h03, 8'h21);
        check(cfg_bytes[7:0] == 8'h21, "R6 writable after unlock", 48'(cfg_bytes[7:0]), 48'h21);

        // R8 stall-learn held until done
        wr(8'h07, 8'h28);
        repeat (4) idle();
        check(cfg_bytes[37] == 1, "R8 learn held", 48'(cfg_bytes[37]), 1);
        tick(0, 0, 0, 0, 0, 1);
        check(cfg_bytes[39:32] == 8'h08, "R8 learn cleared by done", 48'(cfg_bytes[39:32]), 48'h08);
        tick(1, 8'h07, 8'h20, 0, 0, 1);
        check(cfg_bytes[37] == 1, "R8 write wins over done", 48'(cfg_bytes[37]), 1);
        tick(0, 0, 0, 0, 0, 1);

        // R10 count sampling
        count_in = 8'h77;
        idle();
        rd(8'h09, v); check(v == 8'h77, "R10 count sampled", 48'(v), 48'h77);
        count_in = 8'h03;
        idle();
        rd(8'h09, v); check(v == 8'h03, "R10 count follows", 48'(v), 48'h03);

        // mixed traffic against the model
        for (int i = 0; i < 200; i++) begin
            stat1_in = 8'(i * 7);
            count_in = 8'(i * 13);
            tick((i % 3) != 0, 8'(3 + (i % 9)), 8'(i * 29 + 5), (i % 2) == 0, 8'(i % 12), (i % 11) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        done = 1;
        $finish;
    end
endmodule